// File: doc/BRIEF.md
# Scatter Segment Descriptor Splitter

This block turns a list of scatter segments into a bus-master DMA descriptor table. Each segment arrives as a 32-bit bus address and a byte length on a valid/ready handshake, with a flag that marks the final segment of a table. The block cuts every segment into pieces that never cross a 64 KB address window. For each piece it emits one descriptor as two 32-bit words on a valid/ready output stream: the address word first, then the count word.

The count word has two encodings. The standard one carries the low 16 bits of the byte count, so a full 64 KB piece reads as zero. The alternate one carries the number of 32-bit words minus one, shifted into the upper half. For hosts that misread a zero count, an option splits each full 64 KB piece into two 32 KB descriptors. The last descriptor of a table is marked as the end of the table. To do this, the block holds each count word back until it knows whether another descriptor follows.

When a table ends, the block pulses a completion strobe and reports how many descriptors it produced. It also reports whether the table ran past its capacity, or whether it came out empty.

Top module: `desc_splitter`

## Requirements
- R1: Each piece takes min(0x10000 − addr[15:0], bytes left in the segment). Its descriptor is the address word followed by the count word. The next piece starts at the address plus that byte count, so no descriptor crosses a 64 KB boundary.
- R2: A segment longer than one piece produces consecutive descriptors until its remaining length is zero. Segments are handled in arrival order.
- R3: With cfg_alt_enc = 0, the count word is {16'h0000, bytes[15:0]}. A 64 KB piece therefore encodes as 0x0000.
- R4: With cfg_split_full = 1 and cfg_alt_enc = 0, a 64 KB piece is emitted as (A, 0x8000) then (A+0x8000, 0x8000). Each of the two counts toward capacity. With cfg_alt_enc = 1 the option has no effect.
- R5: With cfg_alt_enc = 1, the count word is ((bytes >> 2) − 1) << 16.
- R6: The final count word of a table is flagged by out_last. In the standard encoding, its bit 31 is also set. In the alternate encoding, bit 31 stays clear.
- R7: If a table needs more than TABLE_DEPTH descriptors, the block aborts. It emits no further words, including the held count word. It accepts and discards the remaining segments up to the final one, then reports tbl_overflow = 1 and tbl_count = 0.
- R8: A table that produces no descriptors emits no words and reports tbl_empty = 1 and tbl_count = 0.
- R9: A zero-length segment emits nothing. If the final segment has zero length, the end-of-table mark lands on the previous descriptor.
- R10: While out_valid is high and out_ready is low, out_valid, out_word and out_last hold steady.
- R11: tbl_done pulses for one cycle after a table ends. tbl_count, tbl_overflow and tbl_empty then hold until the next table ends. At most one of the two flags is set.
- R12: A synchronous active-high reset returns the block to idle, with seg_ready = 1, out_valid = 0 and all report outputs at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_split_full | input | 1 | Split each 64 KB piece into two 32 KB descriptors |
| cfg_alt_enc | input | 1 | Select the word-count encoding |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Segment accepted when high with seg_valid |
| seg_addr | input | 32 | Segment bus address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the table |
| out_valid | output | 1 | Descriptor word offered |
| out_ready | input | 1 | Downstream takes the word |
| out_word | output | 32 | Address word or count word |
| out_last | output | 1 | Final word of the table |
| tbl_done | output | 1 | One-cycle completion strobe |
| tbl_count | output | CNT_W | Descriptors in the finished table (0 on error) |
| tbl_overflow | output | 1 | Table exceeded TABLE_DEPTH |
| tbl_empty | output | 1 | Table produced no descriptor |

## Verification
The assertions assume that cfg_split_full and cfg_alt_enc change only while no table is in progress. The word-hold and end-marker properties depend on that. They also assume that segments are aligned to 2 bytes in the standard encoding and to 4 bytes in the alternate one, because the alternate count is meaningful only for whole 32-bit words. The stimulus changes the configuration only after a completion strobe. It uses only even lengths and addresses, and multiples of four wherever the alternate encoding is selected. Backpressure on out_ready is random, so held words are exercised across many stall lengths.

// File: rtl/desc_split_pkg.sv
package desc_split_pkg;

    localparam int WORD_W  = 32;
    localparam int WIN_W   = 16;
    localparam int PIECE_W = WIN_W + 1;

    typedef enum logic [1:0] {
        ST_ACCEPT,
        ST_PIECE,
        ST_FINISH,
        ST_DRAIN
    } split_state_e;

    typedef struct packed {
        logic ovf;
        logic empty;
    } tbl_flags_t;

    // Standard encoding: low half of the byte count (64 KB wraps to zero).
    function automatic logic [WORD_W-1:0] enc_std(input logic [PIECE_W-1:0] bytes);
        return {{(WORD_W-WIN_W){1'b0}}, bytes[WIN_W-1:0]};
    endfunction

    // Alternate encoding: (32-bit words - 1) placed in the upper half.
    function automatic logic [WORD_W-1:0] enc_alt(input logic [PIECE_W-1:0] bytes);
        logic [PIECE_W-3:0] words;
        words = bytes[PIECE_W-1:2];
        return {1'b0, words - 1'b1, {WIN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/desc_piece_calc.sv
module desc_piece_calc
    import desc_split_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic [WORD_W-1:0]  addr,
    input  logic [LEN_W-1:0]   rem,
    input  logic               split_en,
    input  logic               alt_en,
    output logic [PIECE_W-1:0] piece,
    output logic [LEN_W-1:0]   rem_next
);
    localparam int CMP_W = (LEN_W > PIECE_W) ? LEN_W : PIECE_W;
    localparam logic [PIECE_W-1:0] FULL_WIN = PIECE_W'(1) << WIN_W;
    localparam logic [PIECE_W-1:0] HALF_WIN = PIECE_W'(1) << (WIN_W - 1);

    logic [PIECE_W-1:0] win_left;
    logic [CMP_W-1:0]   rem_ext;
    logic [CMP_W-1:0]   win_ext;
    logic [PIECE_W-1:0] take;

    always_comb begin
        win_left = FULL_WIN - {1'b0, addr[WIN_W-1:0]};
        rem_ext  = CMP_W'(rem);
        win_ext  = CMP_W'(win_left);
        take     = (rem_ext < win_ext) ? rem_ext[PIECE_W-1:0] : win_left;
        if (split_en && !alt_en && take == FULL_WIN)
            take = HALF_WIN;
        piece    = take;
        rem_next = LEN_W'(rem_ext - CMP_W'(take));
    end

endmodule

// File: rtl/desc_count_enc.sv
module desc_count_enc
    import desc_split_pkg::*;
(
    input  logic [PIECE_W-1:0] piece,
    input  logic               alt_en,
    output logic [WORD_W-1:0]  count_word
);
    always_comb begin
        count_word = alt_en ? enc_alt(piece) : enc_std(piece);
    end
endmodule

// File: rtl/desc_splitter.sv
module desc_splitter
    import desc_split_pkg::*;
#(
    parameter int LEN_W       = 32,
    parameter int TABLE_DEPTH = 256,
    localparam int CNT_W      = $clog2(TABLE_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_split_full,
    input  logic              cfg_alt_enc,
    input  logic              seg_valid,
    output logic              seg_ready,
    input  logic [31:0]       seg_addr,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              seg_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_word,
    output logic              out_last,
    output logic              tbl_done,
    output logic [CNT_W-1:0]  tbl_count,
    output logic              tbl_overflow,
    output logic              tbl_empty
);
    localparam logic [WORD_W-1:0] END_MARK = WORD_W'(1) << (WORD_W - 1);
    localparam logic [CNT_W-1:0]  CAP      = CNT_W'(TABLE_DEPTH);

    split_state_e       state;
    logic [WORD_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   cur_rem;
    logic               last_q;
    logic [WORD_W-1:0]  held_word;
    logic               held_v;
    logic [CNT_W-1:0]   n_desc;

    logic [PIECE_W-1:0] piece;
    logic [LEN_W-1:0]   rem_next;
    logic [WORD_W-1:0]  cnt_word;
    logic               at_cap;
    logic               complete;
    tbl_flags_t         cmpl_flags;
    tbl_flags_t         res_flags;
    logic [CNT_W-1:0]   res_count;
    logic               done_q;

    desc_piece_calc #(.LEN_W(LEN_W)) u_piece (
        .addr     (cur_addr),
        .rem      (cur_rem),
        .split_en (cfg_split_full),
        .alt_en   (cfg_alt_enc),
        .piece    (piece),
        .rem_next (rem_next)
    );

    desc_count_enc u_enc (
        .piece      (piece),
        .alt_en     (cfg_alt_enc),
        .count_word (cnt_word)
    );

    assign at_cap = (n_desc == CAP);

    always_comb begin
        seg_ready = (state == ST_ACCEPT) || (state == ST_DRAIN);
        out_valid = ((state == ST_PIECE) && !at_cap) ||
                    ((state == ST_FINISH) && held_v);
        out_last  = (state == ST_FINISH) && held_v;
        if (state == ST_FINISH)
            out_word = held_word | (cfg_alt_enc ? '0 : END_MARK);
        else
            out_word = held_v ? held_word : cur_addr;
    end

    always_comb begin
        complete   = 1'b0;
        cmpl_flags = '0;
        unique case (state)
            ST_PIECE: if (at_cap && last_q) begin
                complete       = 1'b1;
                cmpl_flags.ovf = 1'b1;
            end
            ST_FINISH: if (!held_v) begin
                complete         = 1'b1;
                cmpl_flags.empty = 1'b1;
            end else if (out_ready) begin
                complete = 1'b1;
            end
            ST_DRAIN: if (seg_valid && seg_last) begin
                complete       = 1'b1;
                cmpl_flags.ovf = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_ACCEPT;
            cur_addr  <= '0;
            cur_rem   <= '0;
            last_q    <= 1'b0;
            held_word <= '0;
            held_v    <= 1'b0;
            n_desc    <= '0;
        end else if (complete) begin
            state  <= ST_ACCEPT;
            held_v <= 1'b0;
            n_desc <= '0;
        end else begin
            unique case (state)
                ST_ACCEPT: if (seg_valid) begin
                    cur_addr <= seg_addr;
                    cur_rem  <= seg_len;
                    last_q   <= seg_last;
                    if (seg_len != '0)
                        state <= ST_PIECE;
                    else if (seg_last)
                        state <= ST_FINISH;
                end
                ST_PIECE: if (at_cap) begin
                    held_v <= 1'b0;
                    state  <= ST_DRAIN;
                end else if (out_ready) begin
                    if (held_v) begin
                        held_v <= 1'b0;
                    end else begin
                        held_word <= cnt_word;
                        held_v    <= 1'b1;
                        n_desc    <= n_desc + CNT_W'(1);
                        cur_addr  <= cur_addr + WORD_W'(piece);
                        cur_rem   <= rem_next;
                        if (rem_next == '0)
                            state <= last_q ? ST_FINISH : ST_ACCEPT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            res_count <= '0;
            res_flags <= '0;
        end else begin
            done_q <= complete;
            if (complete) begin
                res_flags <= cmpl_flags;
                res_count <= (cmpl_flags.ovf || cmpl_flags.empty) ? '0 : n_desc;
            end
        end
    end

    assign tbl_done     = done_q;
    assign tbl_count    = res_count;
    assign tbl_overflow = res_flags.ovf;
    assign tbl_empty    = res_flags.empty;

endmodule

// File: rtl/desc_splitter_chk.sv
module desc_splitter_chk #(
    parameter int TABLE_DEPTH = 256,
    localparam int CNT_W      = $clog2(TABLE_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_alt_enc,
    input logic             seg_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_word,
    input logic             out_last,
    input logic             tbl_done,
    input logic [CNT_W-1:0] tbl_count,
    input logic             tbl_overflow,
    input logic             tbl_empty
);
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_last));

    p_mark_std_r6: assert property (@(posedge clk) disable iff (rst)
        out_last && !cfg_alt_enc |-> out_word[31]);

    p_mark_alt_r6: assert property (@(posedge clk) disable iff (rst)
        out_last && cfg_alt_enc |-> !out_word[31]);

    p_last_valid_r6: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    p_ovf_zero_r7: assert property (@(posedge clk) disable iff (rst)
        tbl_overflow |-> tbl_count == '0);

    p_cap_r7: assert property (@(posedge clk) disable iff (rst)
        tbl_count <= CNT_W'(TABLE_DEPTH));

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (rst)
        tbl_empty |-> tbl_count == '0);

    p_flags_excl_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tbl_overflow, tbl_empty}));

    p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        tbl_done |=> !tbl_done);

    p_side_r12: assert property (@(posedge clk) disable iff (rst)
        !(seg_ready && out_valid));

endmodule

bind desc_splitter desc_splitter_chk #(.TABLE_DEPTH(TABLE_DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_alt_enc  (cfg_alt_enc),
    .seg_ready    (seg_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_word     (out_word),
    .out_last     (out_last),
    .tbl_done     (tbl_done),
    .tbl_count    (tbl_count),
    .tbl_overflow (tbl_overflow),
    .tbl_empty    (tbl_empty)
);

// File: tb/desc_splitter_tb.sv
module desc_splitter_tb;

    localparam int DEPTH = 8;
    localparam int LEN_W = 32;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_split_full = 1'b0;
    logic             cfg_alt_enc = 1'b0;
    logic             seg_valid = 1'b0;
    logic             seg_ready;
    logic [31:0]      seg_addr = '0;
    logic [LEN_W-1:0] seg_len = '0;
    logic             seg_last = 1'b0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [31:0]      out_word;
    logic             out_last;
    logic             tbl_done;
    logic [CNT_W-1:0] tbl_count;
    logic             tbl_overflow;
    logic             tbl_empty;

    typedef struct { logic [31:0] w; logic l; } beat_t;
    typedef struct { int cnt; bit ovf; bit emp; } stat_t;

    beat_t       exp_q[$];
    stat_t       st_q[$];
    logic [31:0] sa[$];
    logic [31:0] sl[$];
    stat_t       last_st;
    int          n_vec = 0;
    int          n_bad = 0;
    string       cur_req = "R12";
    bit          bp = 1'b0;
    bit          wd_fired = 1'b0;

    always #10 clk = ~clk;

    desc_splitter #(.LEN_W(LEN_W), .TABLE_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_split_full(cfg_split_full), .cfg_alt_enc(cfg_alt_enc),
        .seg_valid(seg_valid), .seg_ready(seg_ready),
        .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_word(out_word), .out_last(out_last),
        .tbl_done(tbl_done), .tbl_count(tbl_count),
        .tbl_overflow(tbl_overflow), .tbl_empty(tbl_empty)
    );

    task automatic check(input bit ok, input string what,
                         input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    // Behavioural reference: walks the segment list and produces the word
    // stream plus the final report.
    task automatic model_table(input bit split, input bit alt);
        int          n = 0;
        bit          pv = 1'b0;
        bit          abort = 1'b0;
        logic [31:0] pw = '0;
        logic [31:0] a;
        longint      r;
        longint      b;
        beat_t       bt;
        stat_t       s;
        foreach (sa[i]) begin
            a = sa[i];
            r = longint'(sl[i]);
            while (r > 0 && !abort) begin
                if (n == DEPTH) begin
                    abort = 1'b1;
                end else begin
                    if (pv) begin bt.w = pw; bt.l = 1'b0; exp_q.push_back(bt); end
                    bt.w = a; bt.l = 1'b0; exp_q.push_back(bt);
                    b = 65536 - longint'(a[15:0]);
                    if (b > r) b = r;
                    if (split && !alt && b == 65536) b = 32768;
                    pw = alt ? 32'(((b >> 2) - 1) << 16) : 32'(b % 65536);
                    pv = 1'b1;
                    n++;
                    a = a + 32'(b);
                    r = r - b;
                end
            end
        end
        s.cnt = 0; s.ovf = 1'b0; s.emp = 1'b0;
        if (abort) s.ovf = 1'b1;
        else if (n == 0) s.emp = 1'b1;
        else begin
            bt.w = alt ? pw : (pw | 32'h8000_0000);
            bt.l = 1'b1;
            exp_q.push_back(bt);
            s.cnt = n;
        end
        st_q.push_back(s);
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] l, input bit last);
        bit got;
        seg_valid = 1'b1; seg_addr = a; seg_len = l; seg_last = last;
        do begin
            @(negedge clk);
            got = seg_ready;
            @(posedge clk);
            #2;
        end while (!got);
        seg_valid = 1'b0;
    endtask

    task automatic add(input logic [31:0] a, input logic [31:0] l);
        sa.push_back(a);
        sl.push_back(l);
    endtask

    task automatic run_table(input string req, input bit split, input bit alt, input bit backp);
        @(posedge clk); #2;
        cur_req = req;
        cfg_split_full = split;
        cfg_alt_enc = alt;
        bp = backp;
        model_table(split, alt);
        foreach (sa[i]) send(sa[i], sl[i], i == sa.size() - 1);
        while (st_q.size() != 0 && !wd_fired) @(negedge clk);
        check(exp_q.size() == 0, "words left unsent", exp_q.size(), 0);
        repeat (4) @(negedge clk);
        check(tbl_count == CNT_W'(last_st.cnt) && tbl_overflow == last_st.ovf &&
              tbl_empty == last_st.emp, "R11 report held",
              {tbl_overflow, tbl_empty, tbl_count}, {last_st.ovf, last_st.emp, CNT_W'(last_st.cnt)});
        sa.delete();
        sl.delete();
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            out_ready = bp ? ($urandom_range(0, 3) != 0) : 1'b1;
        end
    end

    always @(negedge clk) begin : monitor
        beat_t b;
        stat_t s;
        if (!rst && !wd_fired) begin
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected word", {out_last, out_word}, 0);
                end else begin
                    b = exp_q.pop_front();
                    check(out_word == b.w && out_last == b.l, "word",
                          {out_last, out_word}, {b.l, b.w});
                end
            end
            if (tbl_done) begin
                if (st_q.size() == 0) begin
                    check(1'b0, "unexpected completion", 1, 0);
                end else begin
                    s = st_q.pop_front();
                    check(tbl_count == CNT_W'(s.cnt) && tbl_overflow == s.ovf &&
                          tbl_empty == s.emp, "report",
                          {tbl_overflow, tbl_empty, tbl_count}, {s.ovf, s.emp, CNT_W'(s.cnt)});
                    last_st = s;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        wd_fired = 1'b1;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        check(seg_ready && !out_valid && !tbl_done && tbl_count == '0 &&
              !tbl_overflow && !tbl_empty, "R12 reset state",
              {seg_ready, out_valid, tbl_done, tbl_overflow, tbl_empty}, 5'b10000);

        add(32'h1000_0100, 32'h200);
        run_table("R1 R3 R6 single", 1'b0, 1'b0, 1'b0);

        add(32'h0001_F000, 32'h3000);
        run_table("R1 R2 crossing", 1'b0, 1'b0, 1'b0);

        add(32'h0000_0000, 32'h3_0000);
        add(32'h0004_FFF0, 32'h20);
        run_table("R2 R3 full pieces", 1'b0, 1'b0, 1'b1);

        add(32'h0000_0000, 32'h3_0000);
        run_table("R4 split", 1'b1, 1'b0, 1'b0);

        add(32'h0003_8000, 32'h1_8000);
        run_table("R4 R10 split unaligned", 1'b1, 1'b0, 1'b1);

        add(32'h0000_0004, 32'h1_0000);
        add(32'h0002_0000, 32'h1_0000);
        run_table("R5 R6 alt", 1'b1, 1'b1, 1'b1);

        add(32'h0000_1000, 32'h0);
        add(32'h0000_2000, 32'h400);
        add(32'h0000_3000, 32'h0);
        add(32'h0000_4000, 32'h0);
        run_table("R9 zero length", 1'b0, 1'b0, 1'b0);

        add(32'h0000_5000, 32'h0);
        run_table("R8 empty", 1'b0, 1'b0, 1'b0);

        add(32'h0000_0000, 32'h8_0000);
        run_table("R7 exact fit", 1'b0, 1'b0, 1'b1);

        add(32'h0000_0000, 32'h9_0000);
        add(32'h0000_0100, 32'h10);
        add(32'h0000_0200, 32'h20);
        run_table("R7 overflow drain", 1'b0, 1'b0, 1'b1);

        add(32'h0000_0000, 32'h4_8000);
        run_table("R7 R4 split overflow", 1'b1, 1'b0, 1'b0);

        add(32'h0007_FFF8, 32'h10);
        add(32'h0010_0000, 32'h800);
        run_table("R1 R10 recovery", 1'b0, 1'b0, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule